// File: doc/BRIEF.md
# Double-Buffered DAC Load Interface

This block is the register front end of a 14-bit digital-to-analog converter. A processor writes into it with an active-low select, an active-low write strobe, a two-bit operation code and a 14-bit data bus. An 8-bit bus fills a low byte buffer and a six-bit upper buffer in separate writes, then issues a transfer that moves both halves into the converter register in one step. A 16-bit bus can skip the buffers and load the converter register directly. In that case the register is transparent while the strobe is held, so the bus drives the output.

The bus-side signals are asynchronous to the block clock. All strobe, operation and data lines pass through a two-flop synchronizer. The combined strobe is active only when select and write are both low. The end of the strobe, when either line rises, yields a one-cycle capture pulse. That pulse commits the operation and data sampled on the last active clock.

Top module: `dac_load_if`

## Requirements
- R1: Reset clears the low buffer, the upper buffer and the converter register to zero. `dac_o` is 0 after reset, and a transfer issued before any load still yields 0.
- R2: The low-buffer load (`sel_i` = 2'b10) stores `data_i[7:0]` in the low buffer and leaves `dac_o` unchanged.
- R3: The upper-buffer load (`sel_i` = 2'b01) stores `data_i[13:8]` in the upper buffer and leaves `dac_o` unchanged.
- R4: The transfer (`sel_i` = 2'b11) sets the converter register to {upper buffer, low buffer}, and `data_i` has no effect.
- R5: The direct load (`sel_i` = 2'b00) writes all 14 data bits into the converter register. The same write also loads the low buffer from bits 7:0 and the upper buffer from bits 13:8, so a later transfer reproduces the value.
- R6: During a direct load, while the synchronized strobe is active, `dac_o` follows the synchronized `data_i` (two clocks of latency). This happens before the strobe ends.
- R7: No register changes, and no transparency occurs, unless `cs_ni` and `wr_ni` are both sampled low on the same clock.
- R8: A write is committed when the strobe ends, whether `wr_ni` or `cs_ni` rises first. The operation and data are taken from the last clock on which the strobe was sampled active. Bus changes after that clock are ignored.
- R9: The committed value appears on `dac_o` after the third rising clock edge following the rise of the strobe. One inactive clock sample between two strobes is enough to separate them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| sel_i | input | 2 | Operation: 00 direct, 01 upper buffer, 10 low buffer, 11 transfer |
| data_i | input | 14 | Write data bus |
| dac_o | output | 14 | Converter register value, or the transparent bus value during a direct load |

## Verification
Two functions can act in the same clock. One is the capture of a strobe that has just ended. The other is the start of the next strobe's synchronized window, which in direct mode also opens the transparent path. The bench provokes this by issuing writes back to back with a single inactive clock sample between them: a low load followed at once by a transfer, and a low load followed at once by a direct load. A behavioural reference keeps a history of sampled bus values and is compared with `dac_o` on every clock. Explicit end-value checks confirm that neither write was lost or mixed with the other.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  typedef enum logic [1:0] {
    OP_DIRECT = 2'b00,
    OP_HIGH   = 2'b01,
    OP_LOW    = 2'b10,
    OP_XFER   = 2'b11
  } op_e;
endpackage

// File: rtl/dac_sync_chain.sv
module dac_sync_chain #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_strobe_edge.sv
module dac_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic wr_n_i,
  output logic act_o,
  output logic cap_o
);
  logic act_q;

  assign act_o = ~cs_n_i & ~wr_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_o;
  end

  // trailing edge of the combined strobe
  assign cap_o = act_q & ~act_o;

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);

  a_r7_needs_both_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> ($past(cs_n_i) == 1'b0 && $past(wr_n_i) == 1'b0));
endmodule

// File: rtl/dac_regs.sv
module dac_regs
  import dac_if_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 6,
  localparam int DW  = LO_W + HI_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  op_e             op_i,
  input  logic [DW-1:0]   data_i,
  output logic [LO_W-1:0] lo_o,
  output logic [HI_W-1:0] hi_o,
  output logic [DW-1:0]   dac_o
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [DW-1:0]   dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      dac_q <= '0;
    end else if (cap_i) begin
      unique case (op_i)
        OP_LOW:  lo_q <= data_i[LO_W-1:0];
        OP_HIGH: hi_q <= data_i[DW-1:LO_W];
        OP_XFER: dac_q <= {hi_q, lo_q};
        default: begin
          lo_q  <= data_i[LO_W-1:0];
          hi_q  <= data_i[DW-1:LO_W];
          dac_q <= data_i;
        end
      endcase
    end
  end

  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign dac_o = dac_q;

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(dac_q) && $stable(lo_q) && $stable(hi_q)));

  a_r2_low_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && op_i == OP_LOW) |=> ($stable(dac_q) && $stable(hi_q)));

  a_r3_high_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && op_i == OP_HIGH) |=> ($stable(dac_q) && $stable(lo_q)));

  a_r4_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && op_i == OP_XFER) |=> (dac_q == {$past(hi_q), $past(lo_q)}));

  a_r5_direct_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && op_i == OP_DIRECT) |=> (dac_q == $past(data_i) && {hi_q, lo_q} == dac_q));
endmodule

// File: rtl/dac_load_if.sv
module dac_load_if
  import dac_if_pkg::*;
#(
  parameter int LO_W        = 8,
  parameter int HI_W        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 wr_ni,
  input  logic [1:0]           sel_i,
  input  logic [LO_W+HI_W-1:0] data_i,
  output logic [LO_W+HI_W-1:0] dac_o
);
  localparam int DW = LO_W + HI_W;
  localparam int BW = DW + 2;

  logic [1:0]    ctl_s;
  logic [BW-1:0] bus_s;
  logic          act, cap;
  op_e           op_s, op_d;
  logic [DW-1:0] data_s, data_d, dac_q;
  logic [LO_W-1:0] lo_buf;
  logic [HI_W-1:0] hi_buf;

  dac_sync_chain #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_ctl_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, wr_ni}), .q_o(ctl_s)
  );

  // bus lines ride the same depth so they stay aligned with the strobe
  dac_sync_chain #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_bus_sync (
    .clk_i, .rst_ni, .d_i({sel_i, data_i}), .q_o(bus_s)
  );

  assign op_s   = op_e'(bus_s[BW-1:DW]);
  assign data_s = bus_s[DW-1:0];

  dac_strobe_edge i_edge (
    .clk_i, .rst_ni, .cs_n_i(ctl_s[1]), .wr_n_i(ctl_s[0]), .act_o(act), .cap_o(cap)
  );

  // hold last sample so the capture sees the final active cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_d   <= OP_DIRECT;
      data_d <= '0;
    end else begin
      op_d   <= op_s;
      data_d <= data_s;
    end
  end

  dac_regs #(.LO_W(LO_W), .HI_W(HI_W)) i_regs (
    .clk_i, .rst_ni, .cap_i(cap), .op_i(op_d), .data_i(data_d),
    .lo_o(lo_buf), .hi_o(hi_buf), .dac_o(dac_q)
  );

  assign dac_o = (act && op_s == OP_DIRECT) ? data_s : dac_q;

  a_r6_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && op_s == OP_DIRECT) |-> (dac_o == data_s));

  a_r7_quiet_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && !cap) |=> (dac_q == $past(dac_q)));
endmodule

// File: tb/test_dac_load_if.sv
module test_dac_load_if;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 14;

  logic clk = 1'b0;
  logic rst_ni, cs_n, wr_n;
  logic [1:0] sel;
  logic [DW-1:0] data, dac_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_load_if i_dac_load_if (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .wr_ni(wr_n),
    .sel_i(sel), .data_i(data), .dac_o(dac_o)
  );

  // reference model: history of samples taken at each rising edge
  logic          h_cs [4];
  logic          h_wr [4];
  logic [1:0]    h_sel[4];
  logic [DW-1:0] h_dat[4];
  logic [7:0]    m_lo;
  logic [5:0]    m_hi;
  logic [DW-1:0] m_dac, m_exp;

  function automatic bit on(int k);
    return !h_cs[k] && !h_wr[k];
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 4; k++) begin
        h_cs[k] = 1'b1; h_wr[k] = 1'b1; h_sel[k] = 2'b00; h_dat[k] = '0;
      end
      m_lo = '0; m_hi = '0; m_dac = '0; m_exp = '0;
    end else begin
      for (int k = 3; k > 0; k--) begin
        h_cs[k] = h_cs[k-1]; h_wr[k] = h_wr[k-1];
        h_sel[k] = h_sel[k-1]; h_dat[k] = h_dat[k-1];
      end
      h_cs[0] = cs_n; h_wr[0] = wr_n; h_sel[0] = sel; h_dat[0] = data;
      if (on(3) && !on(2)) begin
        case (h_sel[3])
          2'b10: m_lo = h_dat[3][7:0];
          2'b01: m_hi = h_dat[3][13:8];
          2'b11: m_dac = {m_hi, m_lo};
          default: begin
            m_lo = h_dat[3][7:0]; m_hi = h_dat[3][13:8]; m_dac = h_dat[3];
          end
        endcase
      end
      m_exp = (on(1) && h_sel[1] == 2'b00) ? h_dat[1] : m_dac;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R9 timing, R6 window)
  always @(negedge clk) begin
    if (rst_ni && !done) chk("R9 cycle", dac_o, m_exp);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge with the bus idle
  task automatic do_write(input logic [1:0] s, input logic [DW-1:0] d, input int lowc,
                          input bit cs_first, input bit mid_chk);
    sel = s; data = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (lowc) @(negedge clk);
    if (mid_chk) chk("R6 transparent", dac_o, d);
    if (cs_first) cs_n = 1'b1;
    else begin wr_n = 1'b1; cs_n = 1'b1; end
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; data = ~d; sel = ~s;
  endtask

  initial begin
    rst_ni = 1'b0; cs_n = 1'b1; wr_n = 1'b1; sel = 2'b00; data = '0;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    chk("R1 reset", dac_o, 14'h0000);
    idle(1);
    do_write(2'b11, 14'h3FFF, 3, 0, 0); idle(5);
    chk("R1 buffers zero", dac_o, 14'h0000);
    do_write(2'b10, 14'h00A5, 3, 0, 0); idle(5);
    chk("R2 low load holds out", dac_o, 14'h0000);
    do_write(2'b01, 14'h2C00, 3, 0, 0); idle(5);
    chk("R3 high load holds out", dac_o, 14'h0000);
    do_write(2'b11, 14'h1234, 3, 0, 0); idle(5);
    chk("R4 transfer", dac_o, 14'h2CA5);
    do_write(2'b00, 14'h1357, 4, 0, 1); idle(5);
    chk("R5 direct", dac_o, 14'h1357);
    do_write(2'b11, 14'h0000, 3, 0, 0); idle(5);
    chk("R5 buffers from direct", dac_o, 14'h1357);
    // select alone
    sel = 2'b00; data = 14'h0F0F; cs_n = 1'b0; wr_n = 1'b1;
    idle(4);
    chk("R7 cs only no transparency", dac_o, 14'h1357);
    cs_n = 1'b1; idle(5);
    chk("R7 cs only", dac_o, 14'h1357);
    // write alone
    sel = 2'b00; data = 14'h0F0F; cs_n = 1'b1; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1; idle(5);
    chk("R7 wr only", dac_o, 14'h1357);
    // select rises first, bus scrambled after
    do_write(2'b00, 14'h2222, 3, 1, 0); idle(5);
    chk("R8 cs ends strobe", dac_o, 14'h2222);
    // one inactive sample between strobes
    do_write(2'b10, 14'h0011, 3, 0, 0);
    do_write(2'b11, 14'h3FFF, 3, 0, 0); idle(5);
    chk("R9 back to back transfer", dac_o, 14'h2211);
    // latency
    do_write(2'b10, 14'h0077, 3, 0, 0); idle(3);
    sel = 2'b11; cs_n = 1'b0; wr_n = 1'b0;
    idle(3);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    chk("R9 latency edge1", dac_o, 14'h2211);
    @(negedge clk);
    chk("R9 latency edge2", dac_o, 14'h2211);
    @(negedge clk);
    chk("R9 latency edge3", dac_o, 14'h2277);
    idle(3);
    // low load then direct with one-sample gap
    do_write(2'b10, 14'h0099, 3, 0, 0);
    do_write(2'b00, 14'h1ABC, 4, 0, 1); idle(5);
    chk("R5 direct after low", dac_o, 14'h1ABC);
    do_write(2'b11, 14'h0000, 3, 0, 0); idle(5);
    chk("R5 direct overwrote low", dac_o, 14'h1ABC);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule